// File: doc/BRIEF.md
# Asynchronously Terminated Bus Master

This block is the bus-cycle engine behind a processor-side master. It runs one read or one write at a time against a slave that may be 8, 16 or 32 bits wide. The slave ends each cycle with an acknowledge that is not tied to the bus clock. A request port takes the address, direction, size code, port width, type bits, a two-phase attribute pair and write data. It answers with a one-cycle done pulse, an error flag and right-justified read data.

On the bus side the block opens each transfer with a one-clock start strobe, which comes with the address, direction, size code, type bits and the start-phase attribute. In the following cycles it presents the data-phase attribute. For a write it also drives the data word on the byte lanes that the size, the two low address bits and the port width select. The acknowledge passes through a synchronizer whose first flop samples on the falling clock edge and whose remaining flops sample on the rising edge. Every rising edge that does not see the synchronized acknowledge is a wait state, and there is no limit on how many there are. When the acknowledge is seen, read data is captured and the write drivers are released. A new transfer can start only after the synchronized acknowledge has been seen low again.

The controller has six states. IDLE goes to START on a legal request and to REJECT on an illegal one. START always goes to WAIT. WAIT stays in WAIT without the synchronized acknowledge and goes to FINISH with it. FINISH goes to RECOVER while the acknowledge is still high, otherwise to IDLE. RECOVER goes to IDLE once the acknowledge is low. REJECT always goes to IDLE.

Top module: `abm_bus_master`

## Requirements
- R1: A request (req_valid high at a rising edge) is accepted only while req_ready is high, which is only in IDLE. A request presented at any other time starts no bus cycle.
- R2: In the start cycle bus_ts is high for exactly one clock. In that cycle bus_a carries the address, bus_rw carries the direction (1 = read, 0 = write), bus_siz carries the size code (0 = byte, 1 = word, 2 = longword, 3 = reserved), bus_tt carries the type bits and bus_atm carries req_atm[1].
- R3: From the clock after the strobe until termination, bus_atm carries req_atm[0]. bus_doe is high in those cycles for writes only, and never together with bus_ts.
- R4: Lane numbering: lane 0 is bus_dout[31:24] and lane 3 is bus_dout[7:0]. Port codes are 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = reserved. The first lane used is as follows. On an 8-bit port it is lane 0. On a 16-bit port it is lane A[1] for a byte and lane 0 for a word. On a 32-bit port it is lane A[1:0] for a byte, lane 2*A[1] for a word and lane 0 for a longword. Write data bytes fill consecutive lanes, most significant byte in the lowest lane, and the unused lanes are zero.
- R5: Read data is taken from the same lanes as in R4 and returned right-justified on req_rdata, with the upper bytes zero.
- R6: Every rising edge without the synchronized acknowledge is a wait state, with no upper bound. During wait states req_done stays low and the write data stays driven.
- R7: An acknowledge raised before a falling clock edge is seen internally at the next rising edge. The transfer terminates at the rising edge after that, so req_done is high in the cycle that follows the second rising edge after the acknowledge was raised.
- R8: req_done is a single-cycle pulse for each accepted request.
- R9: bus_doe is low in the cycle in which req_done is high, and it stays low until the next write.
- R10: A request with a reserved size, a reserved port code or a size wider than the port produces req_done together with req_err and no bus_ts.
- R11: After termination req_ready stays low while the synchronized acknowledge is high. It rises on the second rising edge after the acknowledge is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_addr | input | ADDR_W | Transfer address |
| req_read | input | 1 | 1 = read, 0 = write |
| req_size | input | 2 | Size code (R2) |
| req_port | input | 2 | Port width code (R4) |
| req_tt | input | TT_W | Transfer type bits |
| req_atm | input | 2 | Attribute: [1] start phase, [0] data phase |
| req_wdata | input | DATA_W | Write data, right-justified |
| req_rdata | output | DATA_W | Read data, right-justified |
| req_done | output | 1 | One-cycle termination pulse |
| req_err | output | 1 | Request rejected (with req_done) |
| bus_a | output | ADDR_W | Bus address |
| bus_rw | output | 1 | Bus direction, 1 = read |
| bus_siz | output | 2 | Bus size code |
| bus_tt | output | TT_W | Bus type bits |
| bus_atm | output | 1 | Phase-dependent attribute line |
| bus_ts | output | 1 | Transfer-start strobe |
| bus_dout | output | DATA_W | Data bus output value |
| bus_doe | output | 1 | Data bus output enable (high = drive) |
| bus_din | input | DATA_W | Data bus input value |
| bus_ack | input | 1 | Asynchronous transfer acknowledge |

## Verification
The bench builds the block with its default parameters: a 28-bit address, a 32-bit data bus, two type bits and one rising-edge synchronizer stage after the falling-edge stage. With these values every size and port pairing and every lane position of R4 and R5 can be driven. The two-edge termination latency of R7 becomes an exact cycle count. A wait of forty clocks checks that the wait is unbounded, and acknowledges held for several clocks past done check the recovery gate of R11.

// File: rtl/abm_pkg.sv
package abm_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        PW_8    = 2'd0,
        PW_16   = 2'd1,
        PW_32   = 2'd2,
        PW_RSVD = 2'd3
    } port_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_START   = 3'd1,
        ST_WAIT    = 3'd2,
        ST_FINISH  = 3'd3,
        ST_RECOVER = 3'd4,
        ST_REJECT  = 3'd5
    } state_e;

    // A transfer fits when neither code is reserved and the size is no
    // wider than the port (both codes are log2 of a byte count).
    function automatic logic size_fits(size_e s, port_e p);
        return (s != SZ_RSVD) && (p != PW_RSVD) && (2'(s) <= 2'(p));
    endfunction

endpackage

// File: rtl/abm_ack_sync.sv
module abm_ack_sync #(
    parameter int RISE_STAGES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_async,
    output logic ack_sync
);

    logic                   fall_q;
    logic [RISE_STAGES-1:0] rise_q;

    // First stage on the falling edge: an acknowledge that arrives before
    // mid-cycle is visible at the next rising edge.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fall_q <= 1'b0;
        end else begin
            fall_q <= ack_async;
        end
    end

    generate
        if (RISE_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    rise_q <= '0;
                end else begin
                    rise_q <= fall_q;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    rise_q <= '0;
                end else begin
                    rise_q <= {rise_q[RISE_STAGES-2:0], fall_q};
                end
            end
        end
    endgenerate

    assign ack_sync = rise_q[RISE_STAGES-1];

endmodule

// File: rtl/abm_lane_steer.sv
module abm_lane_steer
    import abm_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  size_e             siz,
    input  port_e             pw,
    input  logic [1:0]        a_lo,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic [DATA_W-1:0] rdata
);

    localparam int LANES = DATA_W / 8;
    localparam int LW    = $clog2(LANES) + 1;

    logic [LW-1:0] first;
    logic [LW-1:0] count;
    logic          legal;

    always_comb begin
        legal = size_fits(siz, pw);
        unique case (siz)
            SZ_BYTE: count = LW'(1);
            SZ_WORD: count = LW'(2);
            SZ_LONG: count = LW'(4);
            default: count = LW'(0);
        endcase
        first = '0;
        unique case (pw)
            PW_16: begin
                if (siz == SZ_BYTE) first = LW'(a_lo[1]);
            end
            PW_32: begin
                if (siz == SZ_BYTE)      first = LW'(a_lo);
                else if (siz == SZ_WORD) first = LW'({a_lo[1], 1'b0});
            end
            default: first = '0;
        endcase
    end

    // Write side: lane i (0 = most significant) takes item byte pos.
    for (genvar i = 0; i < LANES; i++) begin : g_wlane
        logic          sel;
        logic [LW-1:0] pos;
        assign sel = legal && (LW'(i) >= first) && (LW'(i) < first + count);
        assign pos = first + count - LW'(1) - LW'(i);
        assign dout[8*(LANES-1-i) +: 8] = sel ? wdata[8*pos[LW-2:0] +: 8] : 8'h00;
    end

    // Read side: item byte j (0 = least significant) comes from lane src.
    for (genvar j = 0; j < LANES; j++) begin : g_rbyte
        logic [LW-1:0] src;
        logic [LW-2:0] lane_up;
        assign src     = first + count - LW'(1) - LW'(j);
        assign lane_up = (LW-1)'(LANES - 1) - src[LW-2:0];
        assign rdata[8*j +: 8] = (legal && (LW'(j) < count)) ? din[8*lane_up +: 8] : 8'h00;
    end

endmodule

// File: rtl/abm_ctrl.sv
module abm_ctrl
    import abm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_legal,
    input  logic ack_sync,
    output logic ready,
    output logic start_ph,
    output logic data_ph,
    output logic done,
    output logic err,
    output logic load,
    output logic capture
);

    state_e state_q;
    state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) state_d = req_legal ? ST_START : ST_REJECT;
            end
            ST_START:   state_d = ST_WAIT;
            ST_WAIT: begin
                if (ack_sync) state_d = ST_FINISH;
            end
            ST_FINISH:  state_d = ack_sync ? ST_RECOVER : ST_IDLE;
            ST_RECOVER: state_d = ack_sync ? ST_RECOVER : ST_IDLE;
            ST_REJECT:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        ready    = 1'b0;
        start_ph = 1'b0;
        data_ph  = 1'b0;
        done     = 1'b0;
        err      = 1'b0;
        load     = 1'b0;
        capture  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ready = 1'b1;
                load  = req_valid;
            end
            ST_START:  start_ph = 1'b1;
            ST_WAIT: begin
                data_ph = 1'b1;
                capture = ack_sync;
            end
            ST_FINISH: done = 1'b1;
            ST_RECOVER: begin
            end
            ST_REJECT: begin
                done = 1'b1;
                err  = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/abm_bus_master.sv
module abm_bus_master
    import abm_pkg::*;
#(
    parameter int ADDR_W    = 28,
    parameter int DATA_W    = 32,
    parameter int TT_W      = 2,
    parameter int SYNC_RISE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_read,
    input  logic [1:0]        req_size,
    input  logic [1:0]        req_port,
    input  logic [TT_W-1:0]   req_tt,
    input  logic [1:0]        req_atm,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] req_rdata,
    output logic              req_done,
    output logic              req_err,
    output logic [ADDR_W-1:0] bus_a,
    output logic              bus_rw,
    output logic [1:0]        bus_siz,
    output logic [TT_W-1:0]   bus_tt,
    output logic              bus_atm,
    output logic              bus_ts,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    input  logic [DATA_W-1:0] bus_din,
    input  logic              bus_ack
);

    logic              ack_s;
    logic              legal_in;
    logic              start_ph;
    logic              data_ph;
    logic              load;
    logic              capture;

    logic [ADDR_W-1:0] a_q;
    logic              rd_q;
    size_e             siz_q;
    port_e             pw_q;
    logic [TT_W-1:0]   tt_q;
    logic [1:0]        atm_q;
    logic [DATA_W-1:0] wd_q;
    logic [DATA_W-1:0] rdat_q;
    logic [DATA_W-1:0] steer_dout;
    logic [DATA_W-1:0] steer_rdata;

    assign legal_in = size_fits(size_e'(req_size), port_e'(req_port));

    abm_ack_sync #(.RISE_STAGES(SYNC_RISE)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .ack_async (bus_ack),
        .ack_sync  (ack_s)
    );

    abm_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_legal (legal_in),
        .ack_sync  (ack_s),
        .ready     (req_ready),
        .start_ph  (start_ph),
        .data_ph   (data_ph),
        .done      (req_done),
        .err       (req_err),
        .load      (load),
        .capture   (capture)
    );

    abm_lane_steer #(.DATA_W(DATA_W)) u_steer (
        .siz   (siz_q),
        .pw    (pw_q),
        .a_lo  (a_q[1:0]),
        .wdata (wd_q),
        .din   (bus_din),
        .dout  (steer_dout),
        .rdata (steer_rdata)
    );

    // Request hold registers, loaded on acceptance in IDLE
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q   <= '0;
            rd_q  <= 1'b1;
            siz_q <= SZ_BYTE;
            pw_q  <= PW_8;
            tt_q  <= '0;
            atm_q <= '0;
            wd_q  <= '0;
        end else if (load) begin
            a_q   <= req_addr;
            rd_q  <= req_read;
            siz_q <= size_e'(req_size);
            pw_q  <= port_e'(req_port);
            tt_q  <= req_tt;
            atm_q <= req_atm;
            wd_q  <= req_wdata;
        end
    end

    // Read data capture at the terminating edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdat_q <= '0;
        end else if (capture) begin
            rdat_q <= steer_rdata;
        end
    end

    assign req_rdata = rdat_q;
    assign bus_a     = a_q;
    assign bus_siz   = 2'(siz_q);
    assign bus_tt    = tt_q;
    assign bus_ts    = start_ph;
    assign bus_rw    = (start_ph || data_ph) ? rd_q : 1'b1;
    assign bus_atm   = start_ph ? atm_q[1] : (data_ph ? atm_q[0] : 1'b0);
    assign bus_doe   = data_ph && !rd_q;
    assign bus_dout  = bus_doe ? steer_dout : '0;

endmodule

// File: rtl/abm_bus_master_chk.sv
module abm_bus_master_chk #(
    parameter int ADDR_W = 28,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              req_done,
    input logic              req_err,
    input logic              bus_ts,
    input logic              bus_doe,
    input logic              bus_rw,
    input logic              ack_s,
    input logic [ADDR_W-1:0] bus_a,
    input logic [DATA_W-1:0] bus_dout
);

    // R1: nothing moves on the bus or the done line while idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!bus_ts && !bus_doe && !req_done));

    // R2: the start strobe lasts one clock
    p_ts_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ts |=> !bus_ts);

    // R3: data drive only for writes and never in the strobe cycle
    p_drive_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_doe |-> (!bus_rw && !bus_ts));

    // R6: address and write data hold over wait states
    p_wait_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_doe && $past(bus_doe)) |-> ($stable(bus_a) && $stable(bus_dout)));

    // R8: done is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |=> !req_done);

    // R9: bus released when done shows
    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |-> !bus_doe);

    // R10: an error comes with done, straight from idle, with no strobe
    p_reject_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> (req_done && !bus_ts && $past(req_ready)));

    // R11: return to idle after a transfer only once the acknowledge is low
    p_recover_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(req_ready) && !$past(req_err)) |-> !$past(ack_s));

endmodule

bind abm_bus_master abm_bus_master_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .req_done  (req_done),
    .req_err   (req_err),
    .bus_ts    (bus_ts),
    .bus_doe   (bus_doe),
    .bus_rw    (bus_rw),
    .ack_s     (ack_s),
    .bus_a     (bus_a),
    .bus_dout  (bus_dout)
);

// File: tb/tb_abm_bus_master.sv
`timescale 1ns/1ps
module tb_abm_bus_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [27:0] req_addr = '0;
    logic        req_read = 1'b1;
    logic [1:0]  req_size = '0;
    logic [1:0]  req_port = '0;
    logic [1:0]  req_tt = '0;
    logic [1:0]  req_atm = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] req_rdata;
    logic        req_done;
    logic        req_err;
    logic [27:0] bus_a;
    logic        bus_rw;
    logic [1:0]  bus_siz;
    logic [1:0]  bus_tt;
    logic        bus_atm;
    logic        bus_ts;
    logic [31:0] bus_dout;
    logic        bus_doe;
    logic [31:0] bus_din = '0;
    logic        bus_ack = 1'b0;

    always #4 clk = ~clk;

    abm_bus_master dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_read(req_read), .req_size(req_size),
        .req_port(req_port), .req_tt(req_tt), .req_atm(req_atm),
        .req_wdata(req_wdata), .req_rdata(req_rdata), .req_done(req_done),
        .req_err(req_err), .bus_a(bus_a), .bus_rw(bus_rw), .bus_siz(bus_siz),
        .bus_tt(bus_tt), .bus_atm(bus_atm), .bus_ts(bus_ts), .bus_dout(bus_dout),
        .bus_doe(bus_doe), .bus_din(bus_din), .bus_ack(bus_ack)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int ts_cnt  = 0;
    int done_cnt = 0;
    bit slave_busy = 0;
    bit finished = 0;

    typedef struct {
        logic        err;
        logic        rd;
        logic [31:0] rdata;
    } exp_t;
    exp_t sb[$];
    exp_t got;

    // slave-side expectations for the current transfer
    logic [27:0] s_a;
    logic        s_rd;
    logic [1:0]  s_siz, s_tt, s_atm;
    logic [31:0] s_dout, s_din;
    int          s_dly, s_hold;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic int first_lane(int sz, int pw, int a);
        if (pw == 1) return (sz == 0) ? ((a >> 1) & 1) : 0;
        if (pw == 2) return (sz == 0) ? (a & 3) : ((sz == 1) ? (a & 2) : 0);
        return 0;
    endfunction

    function automatic logic [31:0] lanes_out(int sz, int pw, int a, logic [31:0] wd);
        logic [31:0] r = '0;
        int f = first_lane(sz, pw, a);
        int n = 1 << sz;
        for (int k = 0; k < n; k++) r[31-8*(f+k) -: 8] = wd[8*(n-1-k) +: 8];
        return r;
    endfunction

    function automatic logic [31:0] lanes_in(int sz, int pw, int a, logic [31:0] d);
        logic [31:0] r = '0;
        int f = first_lane(sz, pw, a);
        int n = 1 << sz;
        for (int k = 0; k < n; k++) r[8*(n-1-k) +: 8] = d[31-8*(f+k) -: 8];
        return r;
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // Driver: pushes the expected result, sets up the slave, issues the request
    task automatic xfer(input bit rd, input logic [27:0] a, input int sz, input int pw,
                        input logic [1:0] tt, input logic [1:0] atm, input logic [31:0] wd,
                        input logic [31:0] din, input int dly, input int hold, input bit linger);
        exp_t e;
        bit legal = (sz < 3) && (pw < 3) && (sz <= pw);
        int ts0 = ts_cnt;
        int dc0 = done_cnt;
        e.err   = !legal;
        e.rd    = rd;
        e.rdata = legal ? lanes_in(sz, pw, int'(a[1:0]), din) : '0;
        sb.push_back(e);
        s_a = a; s_rd = rd; s_siz = 2'(sz); s_tt = tt; s_atm = atm;
        s_dout = legal ? lanes_out(sz, pw, int'(a[1:0]), wd) : '0;
        s_din = din; s_dly = dly; s_hold = hold;
        @(posedge clk); #1;
        while (!req_ready) begin @(posedge clk); #1; end
        #1;
        req_valid = 1'b1; req_read = rd; req_addr = a; req_size = 2'(sz);
        req_port = 2'(pw); req_tt = tt; req_atm = atm; req_wdata = wd;
        @(posedge clk);
        if (linger) begin
            // R1: keep presenting a request while the controller is busy
            repeat (2) @(posedge clk);
        end
        #2 req_valid = 1'b0;
        while (done_cnt == dc0) begin @(posedge clk); #1; end
        if (!legal) begin
            chk("R10 no strobe on reject", 32'(ts_cnt - ts0), 32'd0);
            @(posedge clk); #1;
            chk("R10 ready after reject", {31'd0, req_ready}, 32'd1);
        end else begin
            while (slave_busy) begin @(posedge clk); #1; end
            chk("R1 one bus cycle per request", 32'(ts_cnt - ts0), 32'd1);
        end
        chk("R8 one done per request", 32'(done_cnt - dc0), 32'd1);
    endtask

    // Monitor: pops and compares on each done pulse
    always @(posedge clk) begin
        #1;
        if (rst_n && req_done) begin
            done_cnt++;
            if (sb.size() == 0) begin
                chk("R8 unexpected done", 32'd1, 32'd0);
            end else begin
                got = sb.pop_front();
                chk("R10 error flag", {31'd0, req_err}, {31'd0, got.err});
                if (got.rd && !got.err) chk("R5 read data", req_rdata, got.rdata);
            end
        end
    end

    // Slave model: checks both bus phases, acknowledges, checks timing
    initial begin
        forever begin
            @(posedge clk); #1;
            if (rst_n && bus_ts) begin
                slave_busy = 1;
                ts_cnt++;
                chk("R2 address", {4'd0, bus_a}, {4'd0, s_a});
                chk("R2 direction", {31'd0, bus_rw}, {31'd0, s_rd});
                chk("R2 size code", {30'd0, bus_siz}, {30'd0, s_siz});
                chk("R2 type bits", {30'd0, bus_tt}, {30'd0, s_tt});
                chk("R2 start attribute", {31'd0, bus_atm}, {31'd0, s_atm[1]});
                chk("R3 no drive in strobe", {31'd0, bus_doe}, 32'd0);
                @(posedge clk); #1;
                chk("R2 strobe one clock", {31'd0, bus_ts}, 32'd0);
                chk("R3 data attribute", {31'd0, bus_atm}, {31'd0, s_atm[0]});
                chk("R3 drive on write only", {31'd0, bus_doe}, {31'd0, !s_rd});
                if (!s_rd) chk("R4 write lanes", bus_dout, s_dout);
                for (int w = 0; w < s_dly; w++) begin
                    @(posedge clk); #1;
                    chk("R6 wait state no done", {31'd0, req_done}, 32'd0);
                    if (!s_rd) chk("R6 data held in wait", bus_dout, s_dout);
                end
                #2;
                bus_ack = 1'b1;
                bus_din = s_din;
                @(posedge clk); #1;
                chk("R7 not yet terminated", {31'd0, req_done}, 32'd0);
                @(posedge clk); #1;
                chk("R7 termination latency", {31'd0, req_done}, 32'd1);
                chk("R9 bus released", {31'd0, bus_doe}, 32'd0);
                @(posedge clk); #1;
                chk("R8 done single cycle", {31'd0, req_done}, 32'd0);
                chk("R11 held while ack high", {31'd0, req_ready}, 32'd0);
                for (int h = 0; h < s_hold; h++) begin
                    @(posedge clk); #1;
                    chk("R11 held while ack high", {31'd0, req_ready}, 32'd0);
                end
                #2;
                bus_ack = 1'b0;
                bus_din = '0;
                @(posedge clk); #1;
                chk("R11 still held", {31'd0, req_ready}, 32'd0);
                @(posedge clk); #1;
                chk("R11 ready after ack low", {31'd0, req_ready}, 32'd1);
                slave_busy = 0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset ready", {31'd0, req_ready}, 32'd1);
        chk("R2 reset strobe", {31'd0, bus_ts}, 32'd0);
        chk("R3 reset drive", {31'd0, bus_doe}, 32'd0);
        chk("R8 reset done", {31'd0, req_done}, 32'd0);
        chk("R2 reset direction", {31'd0, bus_rw}, 32'd1);
        #1 rst_n = 1'b1;
        // reads across ports and lanes (R4/R5)
        xfer(1, 28'h0000013, 0, 0, 2'b01, 2'b10, '0, 32'hA1B2C3D4, 0, 0, 0);
        xfer(1, 28'h0000100, 1, 1, 2'b10, 2'b01, '0, 32'hA1B2C3D4, 3, 2, 0);
        xfer(1, 28'h0000102, 0, 1, 2'b11, 2'b11, '0, 32'h11223344, 1, 0, 0);
        xfer(1, 28'h0000202, 0, 2, 2'b00, 2'b00, '0, 32'h11223344, 0, 1, 0);
        xfer(1, 28'h0000203, 0, 2, 2'b01, 2'b10, '0, 32'h11223344, 2, 0, 0);
        xfer(1, 28'h0000206, 1, 2, 2'b10, 2'b01, '0, 32'h5566AA99, 0, 0, 0);
        xfer(1, 28'hFFFFFFC, 2, 2, 2'b11, 2'b10, '0, 32'hCAFEF00D, 40, 0, 0);
        // writes (R3/R4)
        xfer(0, 28'h0000301, 0, 0, 2'b01, 2'b01, 32'h00000055, '0, 0, 0, 0);
        xfer(0, 28'h0000302, 1, 2, 2'b10, 2'b10, 32'h00001234, '0, 2, 1, 0);
        xfer(0, 28'h0000305, 0, 2, 2'b00, 2'b11, 32'h00000077, '0, 1, 0, 0);
        xfer(0, 28'h0000402, 0, 1, 2'b11, 2'b00, 32'h000000E7, '0, 0, 0, 0);
        xfer(0, 28'h0000500, 2, 2, 2'b01, 2'b10, 32'hDEADBEEF, '0, 5, 0, 1);
        // rejections (R10)
        xfer(1, 28'h0000600, 1, 0, 2'b00, 2'b00, '0, '0, 0, 0, 0);
        xfer(0, 28'h0000604, 2, 1, 2'b00, 2'b00, 32'h1, '0, 0, 0, 0);
        xfer(1, 28'h0000608, 3, 2, 2'b00, 2'b00, '0, '0, 0, 0, 0);
        xfer(0, 28'h000060C, 0, 3, 2'b00, 2'b00, 32'h2, '0, 0, 0, 0);
        // long acknowledge hold, then back-to-back (R11)
        xfer(1, 28'h0000700, 2, 2, 2'b01, 2'b01, '0, 32'h0BADC0DE, 0, 6, 0);
        xfer(0, 28'h0000704, 2, 2, 2'b10, 2'b10, 32'h76543210, '0, 0, 0, 0);
        repeat (4) @(posedge clk);
        chk("R8 scoreboard drained", 32'(sb.size()), 32'd0);
        finish_run();
    end

endmodule